// File: doc/BRIEF.md
# Base-Page Dual-Stack Engine

This block is the stack datapath of a small byte-oriented stack processor. It holds the top-of-stack byte, the instruction pointer and two 8-bit stack pointers. Both pointers are offsets into a 256-byte page whose 16-bit start address is supplied by the surrounding core. The data stack climbs upward through the page. The return stack descends from the top of the page toward it. The top data element lives in a register, and the element beneath it is read from memory.

Four command strobes start the operations: push a byte, pop a byte, call a subroutine, return from one. Push and pop each take two steps. Call and return each take three, because the 16-bit instruction pointer is moved one byte per step. Every step uses at most one single-cycle access on a byte-wide memory port. The memory read is combinational, and writes take effect at the clock edge. While no command is running, the block reads the byte under the data pointer, so the second stack element is always visible. Instruction decode, the ALU and memory arbitration belong to other blocks.

Top module: `bp_stack_engine`

## Requirements
- R1: After a synchronous active-low reset, the data pointer is 0x00, the return pointer is 0xFF, the top-of-stack byte and the instruction pointer are zero, and busy, done and overflow are low.
- R2: Every stack access goes to base_page + pointer, with the pointer zero-extended to 16 bits. Pointers wrap modulo 256, so the address never leaves the page. A step never reads and writes in the same cycle.
- R3: A push first increments the data pointer. It then writes the old top-of-stack byte at base_page + new pointer, and then loads push_byte into the top-of-stack register.
- R4: A pop places the old top-of-stack byte on pop_byte. It then loads the top-of-stack register from base_page + data pointer, and then decrements the data pointer.
- R5: A call writes the high byte of the instruction pointer at base_page + return pointer and decrements the pointer. It then writes the low byte at the new location and decrements again. Finally it loads call_target into the instruction pointer.
- R6: A return first increments the return pointer. It then reads the low byte of the instruction pointer from base_page + pointer and increments again. Finally it reads the high byte from base_page + pointer.
- R7: While busy is low, next_byte equals the memory byte at base_page + data pointer.
- R8: busy is high from the cycle after a strobe is accepted until the last step. done is high for exactly one cycle: the third cycle after acceptance for push and pop, the fourth for call and return. Strobes that arrive while busy is high are ignored.
- R9: When several strobes arrive together while idle, exactly one is executed, with priority call, then return, then push, then pop. The others are dropped.
- R10: A push accepted when the data pointer plus one equals the return pointer sets overflow. The push still completes, and overflow stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_page | input | 16 | Start address of the stack page |
| cmd_push | input | 1 | Push strobe |
| cmd_pop | input | 1 | Pop strobe |
| cmd_call | input | 1 | Call strobe |
| cmd_ret | input | 1 | Return strobe |
| push_byte | input | 8 | Byte to push |
| call_target | input | 16 | Subroutine address for a call |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data (combinational) |
| tos | output | 8 | Top-of-stack byte |
| next_byte | output | 8 | Second data-stack element, valid while idle |
| pop_byte | output | 8 | Byte removed by the last pop |
| ip | output | 16 | Instruction pointer |
| dsp | output | 8 | Data stack pointer |
| rsp | output | 8 | Return stack pointer |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | Sticky stack-collision flag |

## Verification
Two situations put two functions in the same cycle. The first is several command strobes raised on the same idle edge. The second is a strobe that arrives while an earlier command is still running, including one raised during the final step. The bench raises push and pop together, call and push together, and return and push together. It checks from pointers, the instruction pointer and memory contents that only the higher-priority operation ran. It also raises a pop in the middle of a running push and confirms that the data pointer moved by exactly one and the top byte is the pushed value.

// File: rtl/bpse_pkg.sv
// Shared types for the base-page dual-stack engine.
// Assumes nothing beyond the engine's own step encoding.
package bpse_pkg;

    // One state per memory step; IDLE keeps reading the NEXT location.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_INC,
        ST_PUSH_WR,
        ST_POP_RD,
        ST_POP_DEC,
        ST_CALL_HI,
        ST_CALL_LO,
        ST_CALL_LD,
        ST_RET_INC,
        ST_RET_LO,
        ST_RET_HI
    } bpse_state_e;

    // Command selected on an idle edge after priority resolution.
    typedef enum logic [2:0] {
        OP_NONE,
        OP_PUSH,
        OP_POP,
        OP_CALL,
        OP_RET
    } bpse_op_e;

endpackage

// File: rtl/bpse_ptr.sv
// Byte-wide wrapping stack pointer with increment and decrement controls.
// Assumes inc and dec are never high in the same cycle; inc wins if they are.
module bpse_ptr #(
    parameter int W        = 8,
    parameter bit RST_ONES = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] ptr
);
    localparam logic [W-1:0] RST_VAL = RST_ONES ? {W{1'b1}} : {W{1'b0}};
    localparam logic [W-1:0] ONE     = W'(1);

    // Pointer register: wraps modulo 2**W in both directions.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr <= RST_VAL;
        else if (inc) ptr <= ptr + ONE;
        else if (dec) ptr <= ptr - ONE;
    end
endmodule

// File: rtl/bpse_ctrl.sv
// Step sequencer: accepts one command per idle cycle by fixed priority
// (call, return, push, pop) and walks its memory steps in order.
// Assumes strobes are single-cycle; strobes seen while not idle are dropped.
module bpse_ctrl
    import bpse_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_push,
    input  logic        cmd_pop,
    input  logic        cmd_call,
    input  logic        cmd_ret,
    output bpse_state_e state,
    output bpse_op_e    accept,
    output logic        done
);
    bpse_state_e state_nx;
    logic        last_step;

    // Priority resolution, only while idle.
    always_comb begin
        accept = OP_NONE;
        if (state == ST_IDLE) begin
            if (cmd_call)      accept = OP_CALL;
            else if (cmd_ret)  accept = OP_RET;
            else if (cmd_push) accept = OP_PUSH;
            else if (cmd_pop)  accept = OP_POP;
        end
    end

    // Next-step selection.
    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE: begin
                unique case (accept)
                    OP_PUSH: state_nx = ST_PUSH_INC;
                    OP_POP:  state_nx = ST_POP_RD;
                    OP_CALL: state_nx = ST_CALL_HI;
                    OP_RET:  state_nx = ST_RET_INC;
                    default: state_nx = ST_IDLE;
                endcase
            end
            ST_PUSH_INC: state_nx = ST_PUSH_WR;
            ST_POP_RD:   state_nx = ST_POP_DEC;
            ST_CALL_HI:  state_nx = ST_CALL_LO;
            ST_CALL_LO:  state_nx = ST_CALL_LD;
            ST_RET_INC:  state_nx = ST_RET_LO;
            ST_RET_LO:   state_nx = ST_RET_HI;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Last step of each command.
    always_comb begin
        last_step = (state == ST_PUSH_WR) || (state == ST_POP_DEC) ||
                    (state == ST_CALL_LD) || (state == ST_RET_HI);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Completion pulse, one cycle after the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= last_step;
    end
endmodule

// File: rtl/bpse_memif.sv
// Memory request generator: maps the current step to one byte access at
// base + pointer. Idle cycles read base + data pointer so that the second
// stack element is always on the read data bus.
// Assumes a memory with combinational read and edge-triggered write.
module bpse_memif
    import bpse_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2 * DATA_W
) (
    input  bpse_state_e       state,
    input  logic [ADDR_W-1:0] base,
    input  logic [DATA_W-1:0] dptr,
    input  logic [DATA_W-1:0] rptr,
    input  logic [DATA_W-1:0] tos,
    input  logic [ADDR_W-1:0] ip,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int EXT_W = ADDR_W - DATA_W;

    logic use_data_ptr;

    // Select which pointer the step uses.
    always_comb begin
        use_data_ptr = (state == ST_IDLE) || (state == ST_PUSH_INC) ||
                       (state == ST_PUSH_WR) || (state == ST_POP_RD) ||
                       (state == ST_POP_DEC);
    end

    // Address: base plus zero-extended pointer.
    always_comb begin
        if (use_data_ptr) mem_addr = base + {{EXT_W{1'b0}}, dptr};
        else              mem_addr = base + {{EXT_W{1'b0}}, rptr};
    end

    // Read/write strobes and write data per step.
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = '0;
        unique case (state)
            ST_IDLE, ST_POP_RD, ST_RET_LO, ST_RET_HI: mem_rd = 1'b1;
            ST_PUSH_WR: begin
                mem_wr    = 1'b1;
                mem_wdata = tos;
            end
            ST_CALL_HI: begin
                mem_wr    = 1'b1;
                mem_wdata = ip[ADDR_W-1:DATA_W];
            end
            ST_CALL_LO: begin
                mem_wr    = 1'b1;
                mem_wdata = ip[DATA_W-1:0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bp_stack_engine.sv
// Base-page dual-stack engine: top-of-stack and instruction pointer
// registers, data and return stack pointers, and the push, pop, call and
// return step sequences on a byte-wide memory port.
// Assumes the instruction pointer is exactly two bytes wide.
module bp_stack_engine
    import bpse_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*DATA_W-1:0]   base_page,
    input  logic                  cmd_push,
    input  logic                  cmd_pop,
    input  logic                  cmd_call,
    input  logic                  cmd_ret,
    input  logic [DATA_W-1:0]     push_byte,
    input  logic [2*DATA_W-1:0]   call_target,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic [2*DATA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic [DATA_W-1:0]     tos,
    output logic [DATA_W-1:0]     next_byte,
    output logic [DATA_W-1:0]     pop_byte,
    output logic [2*DATA_W-1:0]   ip,
    output logic [DATA_W-1:0]     dsp,
    output logic [DATA_W-1:0]     rsp,
    output logic                  busy,
    output logic                  done,
    output logic                  overflow
);
    localparam int          ADDR_W = 2 * DATA_W;
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    bpse_state_e state;
    bpse_op_e    accept;
    logic [DATA_W-1:0] pend_byte;
    logic [ADDR_W-1:0] pend_target;
    logic dsp_inc, dsp_dec, rsp_inc, rsp_dec;

    bpse_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_push (cmd_push),
        .cmd_pop  (cmd_pop),
        .cmd_call (cmd_call),
        .cmd_ret  (cmd_ret),
        .state    (state),
        .accept   (accept),
        .done     (done)
    );

    // Pointer step controls derived from the current step.
    always_comb begin
        dsp_inc = (state == ST_PUSH_INC);
        dsp_dec = (state == ST_POP_DEC);
        rsp_dec = (state == ST_CALL_HI) || (state == ST_CALL_LO);
        rsp_inc = (state == ST_RET_INC) || (state == ST_RET_LO);
    end

    bpse_ptr #(.W(DATA_W), .RST_ONES(1'b0)) u_dptr (
        .clk (clk),
        .rst_n (rst_n),
        .inc (dsp_inc),
        .dec (dsp_dec),
        .ptr (dsp)
    );

    bpse_ptr #(.W(DATA_W), .RST_ONES(1'b1)) u_rptr (
        .clk (clk),
        .rst_n (rst_n),
        .inc (rsp_inc),
        .dec (rsp_dec),
        .ptr (rsp)
    );

    bpse_memif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_memif (
        .state     (state),
        .base      (base_page),
        .dptr      (dsp),
        .rptr      (rsp),
        .tos       (tos),
        .ip        (ip),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // Busy whenever a step other than idle is running.
    always_comb busy = (state != ST_IDLE);

    // Second stack element comes straight from the idle read.
    always_comb next_byte = mem_rdata;

    // Operand capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_byte   <= '0;
            pend_target <= '0;
        end else begin
            if (accept == OP_PUSH) pend_byte   <= push_byte;
            if (accept == OP_CALL) pend_target <= call_target;
        end
    end

    // Top-of-stack register: loaded by push completion or pop read.
    always_ff @(posedge clk) begin
        if (!rst_n)                  tos <= '0;
        else if (state == ST_PUSH_WR) tos <= pend_byte;
        else if (state == ST_POP_RD)  tos <= mem_rdata;
    end

    // Pop result: the top byte at the moment the pop is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pop_byte <= '0;
        else if (accept == OP_POP)  pop_byte <= tos;
    end

    // Instruction pointer: call target load or byte-serial return restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip <= '0;
        end else begin
            unique case (state)
                ST_CALL_LD: ip <= pend_target;
                ST_RET_LO:  ip[DATA_W-1:0] <= mem_rdata;
                ST_RET_HI:  ip[ADDR_W-1:DATA_W] <= mem_rdata;
                default: ;
            endcase
        end
    end

    // Sticky collision flag for a push that meets the return stack.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overflow <= 1'b0;
        else if ((accept == OP_PUSH) && ((dsp + ONE) == rsp))
            overflow <= 1'b1;
    end
endmodule

// File: rtl/bp_stack_engine_chk.sv
// Property checker for the base-page dual-stack engine, bound to the top.
module bp_stack_engine_chk #(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_push,
    input logic                cmd_pop,
    input logic                cmd_call,
    input logic                cmd_ret,
    input logic [2*DATA_W-1:0] call_target,
    input logic [2*DATA_W-1:0] ip,
    input logic [DATA_W-1:0]   dsp,
    input logic [DATA_W-1:0]   rsp,
    input logic                busy,
    input logic                done,
    input logic                overflow,
    input logic                mem_rd,
    input logic                mem_wr
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
    localparam logic [DATA_W-1:0] TWO = DATA_W'(2);

    logic acc_call, acc_ret, acc_push, acc_pop;

    // Independent view of which command an idle edge takes.
    always_comb begin
        acc_call = !busy && cmd_call;
        acc_ret  = !busy && !cmd_call && cmd_ret;
        acc_push = !busy && !cmd_call && !cmd_ret && cmd_push;
        acc_pop  = !busy && !cmd_call && !cmd_ret && !cmd_push && cmd_pop;
    end

    assert_rw_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_push_dsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_push |-> ##3 (dsp == $past(dsp, 3) + ONE));

    assert_pop_dsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pop |-> ##3 (dsp == $past(dsp, 3) - ONE));

    assert_call_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_call |-> ##4 ((rsp == $past(rsp, 4) - TWO) && (ip == $past(call_target, 4))));

    assert_ret_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ret |-> ##4 (rsp == $past(rsp, 4) + TWO));

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_push || acc_pop || acc_call || acc_ret) |=> busy);

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

bind bp_stack_engine bp_stack_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_push    (cmd_push),
    .cmd_pop     (cmd_pop),
    .cmd_call    (cmd_call),
    .cmd_ret     (cmd_ret),
    .call_target (call_target),
    .ip          (ip),
    .dsp         (dsp),
    .rsp         (rsp),
    .busy        (busy),
    .done        (done),
    .overflow    (overflow),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr)
);

// File: tb/bp_stack_engine_tb_top.sv
// Directed bench for the base-page dual-stack engine with a small RAM.
module bp_stack_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] BASE = 16'h0180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_push = 1'b0, cmd_pop = 1'b0, cmd_call = 1'b0, cmd_ret = 1'b0;
    logic [7:0]  push_byte = '0;
    logic [15:0] call_target = '0;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [7:0]  tos, next_byte, pop_byte, dsp, rsp;
    logic [15:0] ip;
    logic        busy, done, overflow;

    logic [7:0]  ram [1024];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [7:0]  e_dsp, e_rsp, e_tos;
    logic [15:0] e_ip;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural RAM: combinational read, edge write.
    always @(posedge clk) if (mem_wr) ram[mem_addr[9:0]] <= mem_wdata;
    assign mem_rdata = ram[mem_addr[9:0]];

    bp_stack_engine dut_i (
        .clk (clk), .rst_n (rst_n), .base_page (BASE),
        .cmd_push (cmd_push), .cmd_pop (cmd_pop), .cmd_call (cmd_call), .cmd_ret (cmd_ret),
        .push_byte (push_byte), .call_target (call_target),
        .mem_rd (mem_rd), .mem_wr (mem_wr), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
        .tos (tos), .next_byte (next_byte), .pop_byte (pop_byte), .ip (ip),
        .dsp (dsp), .rsp (rsp), .busy (busy), .done (done), .overflow (overflow)
    );

    function automatic logic [9:0] slot(input logic [7:0] p);
        logic [15:0] a;
        a = BASE + {8'h00, p};
        return a[9:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive strobes for one cycle, then follow busy and done.
    task automatic issue(input logic p, input logic q, input logic c, input logic r,
                         input logic [7:0] b, input logic [15:0] t, input int lat);
        cmd_push = p; cmd_pop = q; cmd_call = c; cmd_ret = r;
        push_byte = b; call_target = t;
        @(negedge clk);
        cmd_push = 0; cmd_pop = 0; cmd_call = 0; cmd_ret = 0;
        chk("R8 busy after accept", busy, 1);
        repeat (lat - 1) @(negedge clk);
        chk("R8 done not early", done, 0);
        @(negedge clk);
        chk("R8 done pulse", done, 1);
        chk("R8 idle at done", busy, 0);
    endtask

    task automatic do_push(input logic [7:0] v);
        logic [7:0] old;
        old = e_tos;
        issue(1, 0, 0, 0, v, 16'h0, 2);
        e_dsp = e_dsp + 8'd1;
        e_tos = v;
        chk("R3 push dsp", dsp, e_dsp);
        chk("R3 push tos", tos, e_tos);
        chk("R3 push stored old tos", ram[slot(e_dsp)], old);
        chk("R7 next after push", next_byte, old);
    endtask

    task automatic do_pop();
        logic [7:0] old;
        old = e_tos;
        e_tos = ram[slot(e_dsp)];
        issue(0, 1, 0, 0, 8'h0, 16'h0, 2);
        e_dsp = e_dsp - 8'd1;
        chk("R4 pop result", pop_byte, old);
        chk("R4 pop tos", tos, e_tos);
        chk("R4 pop dsp", dsp, e_dsp);
    endtask

    task automatic do_call(input logic [15:0] t);
        issue(0, 0, 1, 0, 8'h0, t, 3);
        chk("R5 call ip hi stored", ram[slot(e_rsp)], e_ip[15:8]);
        chk("R5 call ip lo stored", ram[slot(e_rsp - 8'd1)], e_ip[7:0]);
        e_rsp = e_rsp - 8'd2;
        e_ip = t;
        chk("R5 call rsp", rsp, e_rsp);
        chk("R5 call ip", ip, e_ip);
    endtask

    task automatic do_ret();
        e_ip = {ram[slot(e_rsp + 8'd2)], ram[slot(e_rsp + 8'd1)]};
        issue(0, 0, 0, 1, 8'h0, 16'h0, 3);
        e_rsp = e_rsp + 8'd2;
        chk("R6 ret rsp", rsp, e_rsp);
        chk("R6 ret ip", ip, e_ip);
    endtask

    task automatic t_reset();
        chk("R1 dsp", dsp, 8'h00);
        chk("R1 rsp", rsp, 8'hFF);
        chk("R1 tos", tos, 8'h00);
        chk("R1 ip", ip, 16'h0000);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 overflow", overflow, 0);
    endtask

    task automatic t_push_pop();
        do_push(8'h11);
        do_push(8'h22);
        do_push(8'h33);
        chk("R7 next idle", next_byte, 8'h22);
        do_pop();
        do_pop();
        chk("R7 next after pops", next_byte, ram[slot(e_dsp)]);
    endtask

    task automatic t_call_ret();
        do_call(16'h1234);
        do_call(16'hABCD);
        do_ret();
        chk("R6 nested return target", ip, 16'h1234);
        do_ret();
        chk("R6 outer return target", ip, 16'h0000);
    endtask

    // A pop raised mid-push must be dropped.
    task automatic t_busy_ignore();
        logic [7:0] old;
        old = e_tos;
        cmd_push = 1; push_byte = 8'h5A;
        @(negedge clk);
        cmd_push = 0; cmd_pop = 1;
        @(negedge clk);
        cmd_pop = 0;
        @(negedge clk);
        chk("R8 done after push", done, 1);
        e_dsp = e_dsp + 8'd1;
        e_tos = 8'h5A;
        repeat (3) @(negedge clk);
        chk("R8 ignored pop dsp", dsp, e_dsp);
        chk("R8 ignored pop tos", tos, e_tos);
        chk("R8 push stored", ram[slot(e_dsp)], old);
    endtask

    task automatic t_priority();
        // push over pop
        issue(1, 1, 0, 0, 8'h77, 16'h0, 2);
        e_dsp = e_dsp + 8'd1; e_tos = 8'h77;
        chk("R9 push beats pop dsp", dsp, e_dsp);
        chk("R9 push beats pop tos", tos, e_tos);
        // call over push
        issue(1, 0, 1, 0, 8'h99, 16'h4321, 3);
        e_rsp = e_rsp - 8'd2;
        chk("R9 call beats push ip", ip, 16'h4321);
        chk("R9 call beats push dsp", dsp, e_dsp);
        chk("R9 call beats push tos", tos, e_tos);
        e_ip = 16'h4321;
        // return over push
        issue(1, 0, 0, 1, 8'h99, 16'h0, 3);
        e_rsp = e_rsp + 8'd2;
        e_ip = 16'h0000;
        chk("R9 ret beats push rsp", rsp, e_rsp);
        chk("R9 ret beats push ip", ip, e_ip);
        chk("R9 ret beats push dsp", dsp, e_dsp);
    endtask

    // Pointer wraps within the page: pop below zero, push back to zero.
    task automatic t_wrap();
        while (e_dsp != 8'h00) do_pop();
        issue(0, 1, 0, 0, 8'h0, 16'h0, 2);
        e_tos = ram[slot(8'h00)];
        e_dsp = 8'hFF;
        chk("R2 dsp wraps down", dsp, 8'hFF);
        chk("R2 next at page top", next_byte, ram[slot(8'hFF)]);
        chk("R2 idle address in page", mem_addr, BASE + 16'h00FF);
        do_push(8'hC3);
        chk("R2 dsp wraps up", dsp, 8'h00);
        chk("R2 write at page start", ram[slot(8'h00)], ram[10'h180]);
    endtask

    task automatic t_overflow();
        while ((e_dsp + 8'd1) != e_rsp) do_push(e_dsp ^ 8'h5C);
        chk("R10 no overflow before collision", overflow, 0);
        do_push(8'hEE);
        chk("R10 overflow set", overflow, 1);
        chk("R10 push completed", dsp, e_rsp);
        do_pop();
        chk("R10 overflow sticky", overflow, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        e_dsp = 8'h00; e_rsp = 8'hFF; e_tos = 8'h00; e_ip = 16'h0000;
        t_reset();
        t_push_pop();
        t_call_ret();
        t_busy_ignore();
        t_priority();
        t_wrap();
        t_overflow();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule